// File: doc/BRIEF.md
# Low-Power Stop Clock Controller

This block puts a small processor system into a low-power stop condition and brings it back out. A stop request arrives together with the processor's current 3-bit interrupt priority mask. The block keeps a copy of that mask and shuts down the processor clock. Two configuration bits are sampled at the same moment. One decides whether the synthesizer VCO and the system clock keep running. The other decides whether the external clock output keeps toggling. Any clock that is shut down is held low.

The controller runs from an always-on reference clock, so it keeps watching for wake-up events while the rest of the system is halted. A wake-up comes from a trace request, from an interrupt at level 7, or from an interrupt whose level is strictly above the stored mask. A synchronous reset also ends the stop condition. If the VCO was shut down, the block turns it back on and then waits a programmable relock interval before it restores the system clock. Restore takes one cycle, in which the system-side clocks come back while the processor clock is still held off. Normal running resumes after that cycle. Every gate enable changes on the falling edge of the reference clock, so the gated outputs never carry a shortened high pulse.

Top module: `lpstop_clkctl`

## Requirements
- R1: After a synchronous reset the block is running: `cpu_clk`, `sys_clk` and `ext_clk` follow `clk`, `vco_en` is 1, `stopped` is 0 and `held_mask` is 0.
- R2: A `stop_req` sampled while running copies `stop_mask` into `held_mask` and enters stop. `stopped` rises after that edge, and `cpu_clk` stays low from the next high phase onward.
- R3: While stopped, an `irq_level` strictly greater than `held_mask` ends stop. A level equal to or below the mask leaves the block stopped.
- R4: `irq_level` 7 always ends stop, even when `held_mask` is 7.
- R5: A `trace_req` sampled while stopped ends stop, whatever the interrupt level.
- R6: With `keep_core` 0 at entry, `sys_clk` and `ext_clk` are held low and `vco_en` is 0 during stop. On wake-up `vco_en` returns to 1, and `stopped` stays high for `relock_cycles`+1 further cycles before restore.
- R7: With `keep_core` 1 at entry, `sys_clk` and `vco_en` keep running during stop. On wake-up `stopped` falls after the very next edge, with no relock wait.
- R8: `ext_clk` toggles during stop only when `keep_ext` and `keep_core` were both 1 at entry. Otherwise it is held low.
- R9: Restore is exactly one cycle, in which `sys_clk` and `ext_clk` run and `cpu_clk` stays low. All three clocks run after it.
- R10: Every gated clock output is low during the low phase of `clk`, and it is low in the high phase whenever its clock is disabled.
- R11: A `stop_req` arriving while the block is not running is ignored, and `held_mask` keeps its value.
- R12: A reset during stop returns the block to running at once and clears `held_mask` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to enter low-power stop |
| stop_mask | input | 3 | Interrupt priority mask presented with the stop request |
| irq_level | input | 3 | Highest pending interrupt level (0 means none) |
| trace_req | input | 1 | Trace exception request (wakes the block) |
| keep_core | input | 1 | 1 keeps the VCO and system clock running during stop |
| keep_ext | input | 1 | 1 keeps the external clock output running during stop |
| relock_cycles | input | 16 | Relock wait length, loaded when wake-up occurs |
| cpu_clk | output | 1 | Gated processor clock |
| sys_clk | output | 1 | Gated system clock |
| ext_clk | output | 1 | Gated external clock output |
| vco_en | output | 1 | Synthesizer VCO enable |
| stopped | output | 1 | High during stop and relock |
| held_mask | output | 3 | Mask captured at stop entry |

## Verification
The relock window is the hardest situation to reach from the ports. It only occurs when stop was entered with the VCO allowed to shut down and a qualifying wake-up then arrives. Its length is also set by a value loaded at the wake edge, not at entry. The stimulus drives stop with `keep_core` low, holds sub-threshold interrupt levels to confirm the block stays asleep, and wakes it with a lower-than-7 level above the mask. A second pass uses a zero relock count and a level-7 wake against a mask of 7. A reference model in the driver tracks the wait cycle by cycle, so every relock cycle and the single restore cycle are compared separately.

// File: rtl/lpstop_pkg.sv
`timescale 1ns/1ps
package lpstop_pkg;

    typedef enum logic [1:0] {
        LP_RUN    = 2'd0,
        LP_HALT   = 2'd1,
        LP_SETTLE = 2'd2,
        LP_RESUME = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic keep_core;
        logic keep_ext;
    } lp_cfg_t;

    typedef struct packed {
        logic cpu;
        logic sys;
        logic ext;
    } lp_gate_t;

    localparam int LP_GATES = 3;

    // Gate request for each state; the processor clock runs only in LP_RUN.
    function automatic lp_gate_t gate_plan(lp_state_e st, lp_cfg_t cfg);
        lp_gate_t g;
        unique case (st)
            LP_RUN:    g = '{cpu: 1'b1, sys: 1'b1, ext: 1'b1};
            LP_HALT:   g = '{cpu: 1'b0, sys: cfg.keep_core,
                             ext: cfg.keep_core & cfg.keep_ext};
            LP_SETTLE: g = '{cpu: 1'b0, sys: 1'b0, ext: 1'b0};
            default:   g = '{cpu: 1'b0, sys: 1'b1, ext: 1'b1};
        endcase
        return g;
    endfunction

    function automatic logic vco_plan(lp_state_e st, lp_cfg_t cfg);
        return !((st == LP_HALT) && !cfg.keep_core);
    endfunction

endpackage

// File: rtl/lpstop_wake.sv
`timescale 1ns/1ps
module lpstop_wake #(
    parameter int PRIO_W = 3
) (
    input  logic [PRIO_W-1:0] irq_level,
    input  logic              trace_req,
    input  logic [PRIO_W-1:0] held_mask,
    output logic              wake
);
    localparam logic [PRIO_W-1:0] TOP_LEVEL = '1;

    logic above_mask;
    logic non_maskable;

    assign above_mask   = irq_level > held_mask;
    assign non_maskable = irq_level == TOP_LEVEL;
    assign wake         = trace_req | above_mask | non_maskable;
endmodule

// File: rtl/lpstop_relock.sv
`timescale 1ns/1ps
module lpstop_relock #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/lpstop_clkgate.sv
`timescale 1ns/1ps
module lpstop_clkgate #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic [N-1:0] en_req,
    output logic [N-1:0] gclk
);
    logic [N-1:0] en_q;

    // Enables move only while clk is low, so an AND gate gives full pulses.
    always_ff @(negedge clk) begin
        en_q <= en_req;
    end

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gclk[i] = clk & en_q[i];
    end
endmodule

// File: rtl/lpstop_clkctl.sv
`timescale 1ns/1ps
module lpstop_clkctl
    import lpstop_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req,
    input  logic [PRIO_W-1:0] stop_mask,
    input  logic [PRIO_W-1:0] irq_level,
    input  logic              trace_req,
    input  logic              keep_core,
    input  logic              keep_ext,
    input  logic [CNT_W-1:0]  relock_cycles,
    output logic              cpu_clk,
    output logic              sys_clk,
    output logic              ext_clk,
    output logic              vco_en,
    output logic              stopped,
    output logic [PRIO_W-1:0] held_mask
);
    lp_state_e         state_q, state_d;
    lp_cfg_t           cfg_q;
    logic [PRIO_W-1:0] mask_q;
    logic              wake;
    logic              relock_done;
    logic              relock_load;
    lp_gate_t          gate_req;
    logic [LP_GATES-1:0] gate_vec;
    logic [LP_GATES-1:0] gclk;

    lpstop_wake #(.PRIO_W(PRIO_W)) u_wake (
        .irq_level (irq_level),
        .trace_req (trace_req),
        .held_mask (mask_q),
        .wake      (wake)
    );

    assign relock_load = (state_q == LP_HALT) && wake && !cfg_q.keep_core;

    lpstop_relock #(.CNT_W(CNT_W)) u_relock (
        .clk      (clk),
        .rst      (rst),
        .load     (relock_load),
        .load_val (relock_cycles),
        .run      (state_q == LP_SETTLE),
        .done     (relock_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_RUN:    if (stop_req) state_d = LP_HALT;
            LP_HALT:   if (wake) state_d = cfg_q.keep_core ? LP_RESUME : LP_SETTLE;
            LP_SETTLE: if (relock_done) state_d = LP_RESUME;
            default:   state_d = LP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LP_RUN;
            mask_q  <= '0;
            cfg_q   <= '{keep_core: 1'b1, keep_ext: 1'b1};
        end else begin
            state_q <= state_d;
            if ((state_q == LP_RUN) && stop_req) begin
                mask_q <= stop_mask;
                cfg_q  <= '{keep_core: keep_core, keep_ext: keep_ext};
            end
        end
    end

    assign gate_req = gate_plan(state_q, cfg_q);
    assign gate_vec = {gate_req.cpu, gate_req.sys, gate_req.ext};

    lpstop_clkgate #(.N(LP_GATES)) u_gate (
        .clk    (clk),
        .en_req (gate_vec),
        .gclk   (gclk)
    );

    assign cpu_clk   = gclk[2];
    assign sys_clk   = gclk[1];
    assign ext_clk   = gclk[0];
    assign vco_en    = vco_plan(state_q, cfg_q);
    assign stopped   = (state_q == LP_HALT) || (state_q == LP_SETTLE);
    assign held_mask = mask_q;
endmodule

// File: rtl/lpstop_chk.sv
`timescale 1ns/1ps
module lpstop_chk
    import lpstop_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input logic              clk,
    input logic              rst,
    input lp_state_e         state,
    input logic              stop_req,
    input logic [PRIO_W-1:0] stop_mask,
    input logic [PRIO_W-1:0] irq_level,
    input logic              trace_req,
    input logic [PRIO_W-1:0] held_mask,
    input logic              vco_en,
    input logic              stopped
);
    localparam logic [PRIO_W-1:0] TOP = '1;

    a_r2_mask_capture: assert property (@(posedge clk) disable iff (rst)
        (state == LP_RUN && stop_req) |=> (held_mask == $past(stop_mask) && stopped));

    a_r3_stay_asleep: assert property (@(posedge clk) disable iff (rst)
        (state == LP_HALT && !trace_req && irq_level != TOP && irq_level <= held_mask)
        |=> state == LP_HALT);

    a_r3_wake_above: assert property (@(posedge clk) disable iff (rst)
        (state == LP_HALT && irq_level > held_mask) |=> state != LP_HALT);

    a_r4_level_top: assert property (@(posedge clk) disable iff (rst)
        (state == LP_HALT && irq_level == TOP) |=> state != LP_HALT);

    a_r5_trace_wake: assert property (@(posedge clk) disable iff (rst)
        (state == LP_HALT && trace_req) |=> state != LP_HALT);

    a_r6_vco_on_relock: assert property (@(posedge clk) disable iff (rst)
        (state == LP_SETTLE) |-> vco_en);

    a_r9_single_restore: assert property (@(posedge clk) disable iff (rst)
        (state == LP_RESUME) |=> state == LP_RUN);

    a_r11_mask_held: assert property (@(posedge clk) disable iff (rst)
        (state != LP_RUN) |=> $stable(held_mask));
endmodule

bind lpstop_clkctl lpstop_chk #(.PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_q),
    .stop_req  (stop_req),
    .stop_mask (stop_mask),
    .irq_level (irq_level),
    .trace_req (trace_req),
    .held_mask (held_mask),
    .vco_en    (vco_en),
    .stopped   (stopped)
);

// File: tb/lpstop_clkctl_test.sv
`timescale 1ns/1ps
module lpstop_clkctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop_req = 1'b0;
    logic [2:0]  stop_mask = '0;
    logic [2:0]  irq_level = '0;
    logic        trace_req = 1'b0;
    logic        keep_core = 1'b0;
    logic        keep_ext = 1'b0;
    logic [15:0] relock_cycles = 16'd3;
    logic        cpu_clk, sys_clk, ext_clk, vco_en, stopped;
    logic [2:0]  held_mask;

    always #2.5 clk = ~clk;

    lpstop_clkctl uut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .stop_mask(stop_mask),
        .irq_level(irq_level), .trace_req(trace_req), .keep_core(keep_core),
        .keep_ext(keep_ext), .relock_cycles(relock_cycles), .cpu_clk(cpu_clk),
        .sys_clk(sys_clk), .ext_clk(ext_clk), .vco_en(vco_en),
        .stopped(stopped), .held_mask(held_mask)
    );

    typedef struct {
        string      req;
        logic       cpu, sys, ext, vco, stp;
        logic [2:0] mask;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   misses = 0;
    bit   low_chk = 1'b0;

    // reference model: 0 run, 1 stop, 2 relock, 3 restore
    int         ms = 0;
    logic [2:0] mmask = '0;
    logic       mkc = 1'b1, mke = 1'b1;
    int         mcnt = 0;

    task automatic apply(input logic r, input logic sr, input logic [2:0] sm,
                         input logic [2:0] irq, input logic tr, input string req);
        exp_t e;
        int   old;
        logic wk;
        @(posedge clk);
        #2;
        rst = r; stop_req = sr; stop_mask = sm; irq_level = irq; trace_req = tr;
        old   = ms;
        e.req = req;
        e.cpu = (old == 0);
        e.sys = (old == 0) || (old == 3) || (old == 1 && mkc);
        e.ext = (old == 0) || (old == 3) || (old == 1 && mkc && mke);
        if (r) begin
            ms = 0; mmask = '0; mkc = 1'b1; mke = 1'b1;
        end else begin
            case (ms)
                0: if (sr) begin ms = 1; mmask = sm; mkc = keep_core; mke = keep_ext; end
                1: begin
                    wk = tr || (irq == 3'd7) || (irq > mmask);
                    if (wk) begin
                        if (mkc) ms = 3;
                        else begin ms = 2; mcnt = int'(relock_cycles); end
                    end
                end
                2: if (mcnt == 0) ms = 3; else mcnt = mcnt - 1;
                default: ms = 0;
            endcase
        end
        e.vco  = !(ms == 1 && !mkc);
        e.stp  = (ms == 1) || (ms == 2);
        e.mask = mmask;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input logic [2:0] irq, input string req);
        for (int i = 0; i < n; i++) apply(1'b0, 1'b0, 3'd0, irq, 1'b0, req);
    endtask

    // monitor: high phase compare against the scoreboard
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = 1'b0;
            vectors++;
            if (cpu_clk !== e.cpu) begin bad = 1; $display("FAIL %s cpu_clk act=%b exp=%b t=%0t", e.req, cpu_clk, e.cpu, $time); end
            if (sys_clk !== e.sys) begin bad = 1; $display("FAIL %s sys_clk act=%b exp=%b t=%0t", e.req, sys_clk, e.sys, $time); end
            if (ext_clk !== e.ext) begin bad = 1; $display("FAIL %s ext_clk act=%b exp=%b t=%0t", e.req, ext_clk, e.ext, $time); end
            if (vco_en !== e.vco)  begin bad = 1; $display("FAIL %s vco_en act=%b exp=%b t=%0t", e.req, vco_en, e.vco, $time); end
            if (stopped !== e.stp) begin bad = 1; $display("FAIL %s stopped act=%b exp=%b t=%0t", e.req, stopped, e.stp, $time); end
            if (held_mask !== e.mask) begin bad = 1; $display("FAIL %s held_mask act=%0d exp=%0d t=%0t", e.req, held_mask, e.mask, $time); end
            if (bad) misses++;
        end
    end

    // R10: all gated outputs low in the low phase
    always @(negedge clk) begin
        #1;
        if (low_chk) begin
            vectors++;
            if ({cpu_clk, sys_clk, ext_clk} !== 3'b000) begin
                misses++;
                $display("FAIL R10 low-phase clocks act=%b exp=000 t=%0t", {cpu_clk, sys_clk, ext_clk}, $time);
            end
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        misses++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        low_chk = 1'b1;
        apply(1'b1, 1'b0, 3'd0, 3'd0, 1'b0, "R1");
        idle(3, 3'd0, "R1");

        // keep_core 0: full shutdown, relock on wake
        keep_core = 1'b0; keep_ext = 1'b1; relock_cycles = 16'd3;
        apply(1'b0, 1'b1, 3'd3, 3'd0, 1'b0, "R2");
        idle(2, 3'd2, "R3");
        idle(2, 3'd3, "R3");
        apply(1'b0, 1'b1, 3'd5, 3'd1, 1'b0, "R11");
        idle(1, 3'd0, "R8");
        apply(1'b0, 1'b0, 3'd0, 3'd4, 1'b0, "R3");
        idle(4, 3'd0, "R6");
        idle(1, 3'd0, "R9");
        idle(2, 3'd0, "R9");

        // keep_core 1, ext off: level 7 against mask 7
        keep_core = 1'b1; keep_ext = 1'b0;
        apply(1'b0, 1'b1, 3'd7, 3'd0, 1'b0, "R7");
        idle(3, 3'd6, "R8");
        apply(1'b0, 1'b0, 3'd0, 3'd7, 1'b0, "R4");
        idle(3, 3'd0, "R7");

        // both kept: trace wake
        keep_ext = 1'b1;
        apply(1'b0, 1'b1, 3'd2, 3'd0, 1'b0, "R8");
        idle(2, 3'd1, "R8");
        apply(1'b0, 1'b0, 3'd0, 3'd0, 1'b1, "R5");
        idle(3, 3'd0, "R9");

        // zero relock length, level 7 wake
        keep_core = 1'b0; relock_cycles = 16'd0;
        apply(1'b0, 1'b1, 3'd7, 3'd0, 1'b0, "R6");
        idle(2, 3'd0, "R6");
        apply(1'b0, 1'b0, 3'd0, 3'd7, 1'b0, "R4");
        idle(4, 3'd0, "R6");

        // reset while stopped
        apply(1'b0, 1'b1, 3'd6, 3'd0, 1'b0, "R12");
        idle(2, 3'd0, "R12");
        apply(1'b1, 1'b0, 3'd0, 3'd0, 1'b0, "R12");
        apply(1'b0, 1'b0, 3'd0, 3'd0, 1'b0, "R12");
        idle(3, 3'd0, "R1");

        @(posedge clk);
        @(posedge clk);
        low_chk = 1'b0;
        finish_run();
    end
endmodule